// File: doc/BRIEF.md
# Pulse-Disciplined Sampling Strobe Generator

This block derives a low-rate sampling strobe (4 kHz at the default settings) from a free-running system clock (50 MHz by default) with a phase accumulator. A once-per-second reference pulse arrives on an asynchronous line. The block synchronises that line and detects its rising edge. At each edge it takes a snapshot of the accumulator and of the number of output periods seen since the previous edge. From the snapshots it computes a step that is applied to the accumulator increment, so that accumulator wrap-around lines up with the reference pulse.

The correction has two parts: the captured phase and the change in phase since the previous pulse. Each part is scaled by a right shift, and the sum is passed through a first-order low-pass stage (another right shift) before it adjusts the increment. The result is clamped to a programmable window. A pulse interval whose period count is implausible is rejected. A lock flag reports a run of good intervals with small phase error.

The controller is a three-state machine:
- `S_ACQ` waits for the first reference edge. The transition *first edge* leads to `S_TRACK`.
- `S_TRACK` counts output periods. The transition *edge seen* leads to `S_EVAL`.
- `S_EVAL` applies or rejects the update. The transition *update done* returns to `S_TRACK` after one cycle.

Top module: `pps_nco_top`

## Requirements
- R1: After reset, `inc_word` equals `NOM_INC`, and `locked`, `samp_stb` and `samp_clk` are 0.
- R2: The accumulator starts at 0 and grows by `inc_word` every clock, modulo 2^ACC_W. `samp_stb` is a one-cycle pulse on each wrap, so with a constant increment the strobes are 2^ACC_W / `inc_word` clocks apart.
- R3: `samp_clk` is the accumulator's most significant bit, which gives a square wave that is high for half of each output period.
- R4: `pps_in` passes through two synchroniser flops and a rising-edge detector. The first detected edge after reset only starts the measurement and leaves `inc_word` unchanged.
- R5: If the number of wraps between two edges lies outside `EXP_CNT` ± `CNT_TOL`, the update is skipped: `inc_word` keeps its value, and the good-interval run and `locked` are cleared.
- R6: Otherwise, let p be the accumulator value captured at the edge, read as signed, and d the signed difference from the previous capture. The increment becomes `inc_word` − S(S(p,PH_SHIFT) + S(d,DF_SHIFT), FILT_SHIFT), where S is an arithmetic right shift that rounds toward zero. A positive phase therefore lowers the increment, and a negative phase raises it.
- R7: The new increment is clamped to the range [`INC_MIN`, `INC_MAX`].
- R8: `locked` rises after `LOCK_RUN` consecutive accepted intervals with |p| < `LOCK_THR`. Any rejected interval, or any interval with a larger phase error, clears it.
- R9: Errors too small to survive the shifts leave `inc_word` unchanged in both signs, so a small positive phase produces no drift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_in | input | 1 | Asynchronous once-per-second reference pulse |
| samp_clk | output | 1 | Square-wave sample clock (accumulator MSB) |
| samp_stb | output | 1 | One-cycle conversion-start strobe per wrap |
| locked | output | 1 | Loop has seen a run of good intervals |
| inc_word | output | ACC_W | Current accumulator increment |

## Verification
The hardest condition to create from the ports is a reference edge whose captured phase falls at a chosen point within the output period. Only that gives exact expected increments, because the phase itself is never visible. The stimulus waits for a strobe, so it knows the accumulator has just wrapped. It then delays the pulse by a fixed number of cycles, which places the capture early, late, or near zero within a margin wider than the synchroniser latency. A short pulse spacing produces the rejected-count case, and a long train of aligned pulses walks the lock run up to its threshold.

// File: rtl/pps_nco_pkg.sv
package pps_nco_pkg;

    typedef enum logic [1:0] {
        S_ACQ   = 2'd0,
        S_TRACK = 2'd1,
        S_EVAL  = 2'd2
    } loop_st_t;

    // arithmetic right shift that rounds toward zero for both signs
    function automatic logic signed [63:0] shr_sym(input logic signed [63:0] x,
                                                   input int unsigned        s);
        logic signed [63:0] mag;
        mag = (x < 0) ? -x : x;
        mag = mag >>> s;
        return (x < 0) ? -mag : mag;
    endfunction

endpackage

// File: rtl/pps_edge_det.sv
module pps_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_async,
    output logic pps_rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pps_async;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign pps_rise = s2 & ~s3;

    // R4
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pps_rise |=> !pps_rise);

endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc,
    output logic [ACC_W-1:0] acc,
    output logic             wrap,
    output logic             stb,
    output logic             msb
);
    logic [ACC_W:0] sum;

    assign sum  = {1'b0, acc} + {1'b0, inc};
    assign wrap = sum[ACC_W];
    assign msb  = acc[ACC_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            stb <= 1'b0;
        end else begin
            acc <= sum[ACC_W-1:0];
            stb <= wrap;
        end
    end

    // R2
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);

endmodule

// File: rtl/disc_ctrl.sv
module disc_ctrl
    import pps_nco_pkg::*;
#(
    parameter int              ACC_W      = 32,
    parameter logic [ACC_W-1:0] NOM_INC   = 32'd343597,
    parameter logic [ACC_W-1:0] INC_MIN   = 32'd339501,
    parameter logic [ACC_W-1:0] INC_MAX   = 32'd347693,
    parameter int              EXP_CNT    = 4000,
    parameter int              CNT_TOL    = 2,
    parameter int              PH_SHIFT   = 12,
    parameter int              DF_SHIFT   = 8,
    parameter int              FILT_SHIFT = 4,
    parameter int              LOCK_RUN   = 8,
    parameter longint          LOCK_THR   = 64'd16777216
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps_rise,
    input  logic             wrap,
    input  logic [ACC_W-1:0] acc_val,
    output logic [ACC_W-1:0] inc_word,
    output logic             locked
);
    localparam int CNT_W = $clog2(EXP_CNT + CNT_TOL + 2) + 1;
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(EXP_CNT - CNT_TOL);
    localparam logic [CNT_W-1:0] CNT_HI  = CNT_W'(EXP_CNT + CNT_TOL);
    localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};
    localparam logic [RUN_W-1:0] RUN_END = RUN_W'(LOCK_RUN);

    loop_st_t st, st_nx;

    logic [CNT_W-1:0] wrap_cnt, cap_cnt;
    logic [ACC_W-1:0] cap_phi, cap_dphi;
    logic [RUN_W-1:0] run;

    logic               cnt_ok, phi_ok;
    logic signed [63:0] phi_x, dphi_x, phi_abs, step, inc_calc;
    logic [ACC_W-1:0]   inc_clamped;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_ACQ;
        else        st <= st_nx;
    end

    // transitions: first edge, edge seen, update done
    always_comb begin
        st_nx = st;
        unique case (st)
            S_ACQ:   if (pps_rise) st_nx = S_TRACK;
            S_TRACK: if (pps_rise) st_nx = S_EVAL;
            S_EVAL:  st_nx = S_TRACK;
            default: st_nx = S_ACQ;
        endcase
    end

    // correction arithmetic
    always_comb begin
        phi_x    = 64'(signed'(cap_phi));
        dphi_x   = 64'(signed'(cap_dphi));
        phi_abs  = (phi_x < 0) ? -phi_x : phi_x;
        phi_ok   = phi_abs < LOCK_THR;
        cnt_ok   = (cap_cnt >= CNT_LO) && (cap_cnt <= CNT_HI);
        step     = shr_sym(shr_sym(phi_x, PH_SHIFT) + shr_sym(dphi_x, DF_SHIFT),
                           FILT_SHIFT);
        inc_calc = signed'(64'(inc_word)) - step;
        if (inc_calc < signed'(64'(INC_MIN)))      inc_clamped = INC_MIN;
        else if (inc_calc > signed'(64'(INC_MAX))) inc_clamped = INC_MAX;
        else                                      inc_clamped = ACC_W'(inc_calc);
    end

    // measurement and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_cnt <= '0;
            cap_cnt  <= '0;
            cap_phi  <= '0;
            cap_dphi <= '0;
            run      <= '0;
            inc_word <= NOM_INC;
            locked   <= 1'b0;
        end else begin
            if (pps_rise) begin
                wrap_cnt <= wrap ? CNT_W'(1) : '0;
                cap_cnt  <= wrap_cnt;
                cap_phi  <= acc_val;
                cap_dphi <= acc_val - cap_phi;
            end else if (wrap && wrap_cnt != CNT_SAT) begin
                wrap_cnt <= wrap_cnt + 1'b1;
            end
            if (st == S_EVAL) begin
                if (!cnt_ok) begin
                    run    <= '0;
                    locked <= 1'b0;
                end else begin
                    inc_word <= inc_clamped;
                    if (!phi_ok) begin
                        run    <= '0;
                        locked <= 1'b0;
                    end else if (run != RUN_END) begin
                        run    <= run + 1'b1;
                        locked <= (run + 1'b1) == RUN_END;
                    end
                end
            end
        end
    end

    // R7
    inc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_word >= INC_MIN) && (inc_word <= INC_MAX));

    // R5
    cnt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_EVAL && !cnt_ok) |=> ($stable(inc_word) && !locked));

    // R6
    inc_when_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(inc_word) |-> ($past(st) == S_EVAL));

    // R8
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(st) == S_EVAL));

    // R4
    acq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ACQ) |=> $stable(inc_word));

endmodule

// File: rtl/pps_nco_top.sv
module pps_nco_top #(
    parameter int              ACC_W      = 32,
    parameter logic [ACC_W-1:0] NOM_INC   = 32'd343597,
    parameter logic [ACC_W-1:0] INC_MIN   = 32'd339501,
    parameter logic [ACC_W-1:0] INC_MAX   = 32'd347693,
    parameter int              EXP_CNT    = 4000,
    parameter int              CNT_TOL    = 2,
    parameter int              PH_SHIFT   = 12,
    parameter int              DF_SHIFT   = 8,
    parameter int              FILT_SHIFT = 4,
    parameter int              LOCK_RUN   = 8,
    parameter longint          LOCK_THR   = 64'd16777216
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps_in,
    output logic             samp_clk,
    output logic             samp_stb,
    output logic             locked,
    output logic [ACC_W-1:0] inc_word
);
    logic             pps_rise, wrap;
    logic [ACC_W-1:0] acc_val;

    pps_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pps_async(pps_in),
        .pps_rise (pps_rise)
    );

    nco_accum #(.ACC_W(ACC_W)) u_nco (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (inc_word),
        .acc  (acc_val),
        .wrap (wrap),
        .stb  (samp_stb),
        .msb  (samp_clk)
    );

    disc_ctrl #(
        .ACC_W(ACC_W), .NOM_INC(NOM_INC), .INC_MIN(INC_MIN), .INC_MAX(INC_MAX),
        .EXP_CNT(EXP_CNT), .CNT_TOL(CNT_TOL), .PH_SHIFT(PH_SHIFT),
        .DF_SHIFT(DF_SHIFT), .FILT_SHIFT(FILT_SHIFT), .LOCK_RUN(LOCK_RUN),
        .LOCK_THR(LOCK_THR)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .pps_rise(pps_rise),
        .wrap    (wrap),
        .acc_val (acc_val),
        .inc_word(inc_word),
        .locked  (locked)
    );

endmodule

// File: tb/test_pps_nco_top.sv
module test_pps_nco_top;
    localparam int W    = 16;
    localparam int NOM  = 1024;
    localparam int SPAN = 512;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pps_in = 1'b0;
    logic         samp_clk, samp_stb, locked;
    logic [W-1:0] inc_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pps_nco_top #(
        .ACC_W(W), .NOM_INC(16'd1024), .INC_MIN(16'd1021), .INC_MAX(16'd1027),
        .EXP_CNT(8), .CNT_TOL(2), .PH_SHIFT(8), .DF_SHIFT(4), .FILT_SHIFT(4),
        .LOCK_RUN(8), .LOCK_THR(64'd4096)
    ) i_pps_nco_top (
        .clk(clk), .rst_n(rst_n), .pps_in(pps_in),
        .samp_clk(samp_clk), .samp_stb(samp_stb),
        .locked(locked), .inc_word(inc_word)
    );

    // scenario table: strobe-relative offset, spacing of pulses, expected increment
    localparam int NROW = 4;
    localparam int ROW_OFF [NROW] = '{0,    40,   20,   40};
    localparam int ROW_SP  [NROW] = '{SPAN, SPAN, SPAN, 192};
    localparam int ROW_INC [NROW] = '{1024, 1027, 1021, 1024};

    task automatic check(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        pps_in = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic align(input int off);
        @(negedge clk);
        while (!samp_stb) @(negedge clk);
        repeat (off) @(negedge clk);
    endtask

    task automatic send_pulses(input int n, input int sp);
        for (int i = 0; i < n; i++) begin
            pps_in = 1'b1;
            repeat (8) @(negedge clk);
            pps_in = 1'b0;
            repeat (sp - 8) @(negedge clk);
        end
    endtask

    initial begin
        int t0;
        int hi;

        do_reset();
        // R1 reset state
        check("R1 inc", int'(inc_word), NOM);
        check("R1 locked", int'(locked), 0);
        check("R1 stb", int'(samp_stb), 0);
        check("R1 clk", int'(samp_clk), 0);

        // R2 strobe spacing with nominal increment
        align(0);
        t0 = 0;
        @(negedge clk);
        t0++;
        while (!samp_stb) begin
            @(negedge clk);
            t0++;
        end
        check("R2 period", t0, 65536 / NOM);

        // R3 high time of the square wave
        while (samp_clk) @(negedge clk);
        while (!samp_clk) @(negedge clk);
        hi = 0;
        while (samp_clk) begin
            hi++;
            @(negedge clk);
        end
        check("R3 high half", hi, 32);

        // table walk: R4 first edge, R6/R7/R9 update, R5 gated count
        for (int r = 0; r < NROW; r++) begin
            do_reset();
            align(ROW_OFF[r]);
            send_pulses(1, ROW_SP[r]);
            check("R4 first edge no update", int'(inc_word), NOM);
            send_pulses(1, SPAN);
            case (r)
                0: check("R9 small phase", int'(inc_word), ROW_INC[r]);
                1: check("R7 clamp high (R6 lag)", int'(inc_word), ROW_INC[r]);
                2: check("R7 clamp low (R6 lead)", int'(inc_word), ROW_INC[r]);
                default: check("R5 gated count", int'(inc_word), ROW_INC[r]);
            endcase
        end

        // R8 lock run
        do_reset();
        align(0);
        send_pulses(8, SPAN);
        check("R8 not yet locked", int'(locked), 0);
        send_pulses(1, SPAN);
        check("R8 locked", int'(locked), 1);
        check("R9 inc held", int'(inc_word), NOM);
        send_pulses(1, 192);
        send_pulses(1, SPAN);
        check("R5 short interval clears lock", int'(locked), 0);
        check("R5 inc kept", int'(inc_word), NOM);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule